// File: doc/BRIEF.md
# Edge Interrupt and Wake Controller

This block is the interrupt front end for a small 8-bit processor core. It watches one external interrupt pin and recognises either its rising or its falling edge, selected by a control bit. Each recognised edge sets a sticky flag that software clears with an explicit write. When the flag, the source enable and the global enable are all set, the block raises a one-cycle request to redirect the core to a fixed vector address. With the same pulse it raises a stack push that carries only the return PC. The core answers with an acknowledge, and the acknowledge clears the global enable.

The block also runs the low-power sleep handshake. A sleep strobe from the core puts the block in its sleep state. In that state, a valid pin edge is caught by a latch clocked by the pin itself, so it needs no system clock, and the latch is then resynchronised. A flagged edge with the source enable set produces a one-cycle wake pulse. Vectoring after wake also needs the global enable. The block then waits until the core retires one instruction before it raises the request, so the instruction after the sleep instruction always completes first.

Top module: `ext_irq_wake_ctrl`

## Requirements
- R1: With `rise_sel` = 1, a 0-to-1 change of `irq_pin` raises `irq_flag`. The flag is seen high after the third rising clock edge that follows the change. A 1-to-0 change leaves the flag unchanged.
- R2: With `rise_sel` = 0, a 1-to-0 change of `irq_pin` raises `irq_flag` with the same latency as in R1. A 0-to-1 change leaves the flag unchanged.
- R3: `irq_flag` is set by a valid edge whatever the values of `int_en` and `gie`. It then stays high until `flag_clr` is high at a clock edge.
- R4: When `flag_clr` and a valid edge event fall on the same clock edge, `irq_flag` is 1 afterwards.
- R5: `vec_req` is high for exactly one cycle. It rises only if, at the preceding edge, the block was awake, no request was awaiting acknowledge, and `irq_flag`, `int_en` and `gie` were all 1. `vec_addr` always reads 0x0004.
- R6: `push_req` is high in exactly the cycles where `vec_req` is high. `push_pc` then holds the `pc_in` value sampled at the edge that raised the request. Taking the interrupt does not change `irq_flag`.
- R7: `vec_ack` while a request is pending clears `gie` at that edge. No new request is raised between a request and its acknowledge.
- R8: `sleep_req` in the running state, with no request raised or pending, enters sleep. While asleep, a valid edge is captured without the clock and sets `irq_flag`. `wake` then pulses for one cycle once `irq_flag` and `int_en` are both 1, including when `int_en` is set only after the edge.
- R9: With `int_en` = 0 during sleep, a valid edge sets `irq_flag` but produces no `wake` pulse.
- R10: After a wake with `gie` = 0, no `vec_req` is raised.
- R11: After a wake with `gie` = 1, `vec_req` stays low until `retire` is seen high. It rises on the edge after the edge that sampled `retire`. `vec_req` is never high while the block is asleep.
- R12: After reset, `irq_flag`, `gie`, `wake`, `vec_req`, `push_req` and `push_pc` are 0, and the block is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 1 | Asynchronous external interrupt pin |
| rise_sel | input | 1 | 1 selects rising edges, 0 selects falling edges |
| int_en | input | 1 | Enable of this interrupt source |
| gie_wr | input | 1 | Software write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| sleep_req | input | 1 | Strobe from the core when it executes its sleep instruction |
| pc_in | input | PC_W | Return PC offered by the core |
| retire | input | 1 | Strobe when the core completes an instruction |
| vec_ack | input | 1 | Core acknowledge of a vector request |
| irq_flag | output | 1 | Sticky interrupt flag |
| gie | output | 1 | Global interrupt enable bit |
| wake | output | 1 | One-cycle wake pulse |
| vec_req | output | 1 | One-cycle request to jump to the vector |
| vec_addr | output | PC_W | Fixed vector address 0x0004 |
| push_req | output | 1 | Stack push of the return PC |
| push_pc | output | PC_W | Return PC to push |

## Verification
Edge detection is driven with both polarities on both pin directions. This separates a detector that reacts to the wrong edge from one that reacts to any change. A flag clear placed on the exact edge of a new event separates edge-wins priority from clear-wins priority. Vectoring is tried with each of the three enabling conditions missing in turn. A cycle-by-cycle reference model catches a request that is too long or arrives too early. Three sleep sequences separate the wake condition from the vector condition and expose any request that jumps ahead of the first retired instruction: enable clear then set late, wake with global enable off, and wake with global enable on.

// File: rtl/eiw_pkg.sv
package eiw_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_RESUME = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic flag;
        logic gie;
        logic wake;
        logic vreq;
        logic wait_ack;
    } irq_status_t;

    function automatic logic is_valid_edge(input logic rise_sel,
                                           input logic now_v,
                                           input logic prev_v);
        return rise_sel ? (now_v & ~prev_v) : (~now_v & prev_v);
    endfunction

endpackage

// File: rtl/eiw_pin_sync.sv
module eiw_pin_sync
    import eiw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_ev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= pin;
            for (int i = 1; i < DEPTH; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    always_comb begin
        edge_ev = is_valid_edge(rise_sel, chain[STAGES-1], chain[STAGES]);
    end

endmodule

// File: rtl/eiw_sleep_capture.sv
module eiw_sleep_capture #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    input  logic armed,
    output logic cap_ev
);
    logic              trig;
    logic              lat_clr;
    logic              held;
    logic [STAGES-1:0] rs;

    always_comb begin
        trig    = rise_sel ? pin : ~pin;
        lat_clr = rst | ~armed;
    end

    // Clockless capture: the pin itself clocks the holding flop.
    always_ff @(posedge trig or posedge lat_clr) begin
        if (lat_clr) begin
            held <= 1'b0;
        end else begin
            held <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            rs <= '0;
        end else begin
            rs[0] <= held;
            for (int i = 1; i < STAGES; i++) begin
                rs[i] <= rs[i-1];
            end
        end
    end

    always_comb begin
        cap_ev = rs[STAGES-1];
    end

endmodule

// File: rtl/eiw_seq.sv
module eiw_seq
    import eiw_pkg::*;
#(
    parameter int PC_W = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ev_awake,
    input  logic            ev_asleep,
    input  logic            int_en,
    input  logic            gie_wr,
    input  logic            gie_wdata,
    input  logic            flag_clr,
    input  logic            sleep_req,
    input  logic            retire,
    input  logic            vec_ack,
    input  logic [PC_W-1:0] pc_in,
    output irq_status_t     status,
    output logic [PC_W-1:0] ret_pc,
    output logic            edge_ev,
    output logic            armed
);
    pwr_state_e      st_q, st_d;
    irq_status_t     s_q, s_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic            take;

    always_comb begin
        edge_ev = (st_q == ST_SLEEP) ? ev_asleep : ev_awake;
        take    = (st_q == ST_RUN) && s_q.flag && int_en && s_q.gie && !s_q.wait_ack;

        s_d  = s_q;
        st_d = st_q;
        pc_d = pc_q;

        if (edge_ev) begin
            s_d.flag = 1'b1;
        end else if (flag_clr) begin
            s_d.flag = 1'b0;
        end

        if (vec_ack && s_q.wait_ack) begin
            s_d.gie = 1'b0;
        end else if (gie_wr) begin
            s_d.gie = gie_wdata;
        end

        if (take) begin
            s_d.wait_ack = 1'b1;
            pc_d         = pc_in;
        end else if (vec_ack) begin
            s_d.wait_ack = 1'b0;
        end

        s_d.vreq = take;
        s_d.wake = 1'b0;

        case (st_q)
            ST_RUN: begin
                if (sleep_req && !take && !s_q.wait_ack) begin
                    st_d = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (s_q.flag && int_en) begin
                    st_d     = ST_RESUME;
                    s_d.wake = 1'b1;
                end
            end
            ST_RESUME: begin
                if (retire) begin
                    st_d = ST_RUN;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_RUN;
            s_q  <= '0;
            pc_q <= '0;
        end else begin
            st_q <= st_d;
            s_q  <= s_d;
            pc_q <= pc_d;
        end
    end

    always_comb begin
        status = s_q;
        ret_pc = pc_q;
        armed  = (st_q == ST_SLEEP);
    end

endmodule

// File: rtl/ext_irq_wake_ctrl.sv
module ext_irq_wake_ctrl
    import eiw_pkg::*;
#(
    parameter int              PC_W        = 13,
    parameter logic [PC_W-1:0] VEC_ADDR    = PC_W'(4),
    parameter int              SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_pin,
    input  logic            rise_sel,
    input  logic            int_en,
    input  logic            gie_wr,
    input  logic            gie_wdata,
    input  logic            flag_clr,
    input  logic            sleep_req,
    input  logic [PC_W-1:0] pc_in,
    input  logic            retire,
    input  logic            vec_ack,
    output logic            irq_flag,
    output logic            gie,
    output logic            wake,
    output logic            vec_req,
    output logic [PC_W-1:0] vec_addr,
    output logic            push_req,
    output logic [PC_W-1:0] push_pc
);
    logic            ev_awake;
    logic            ev_asleep;
    logic            edge_ev;
    logic            asleep;
    logic            wait_pend;
    irq_status_t     stat;
    logic [PC_W-1:0] ret_pc;

    eiw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin      (irq_pin),
        .rise_sel (rise_sel),
        .edge_ev  (ev_awake)
    );

    eiw_sleep_capture #(.STAGES(SYNC_STAGES)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .pin      (irq_pin),
        .rise_sel (rise_sel),
        .armed    (asleep),
        .cap_ev   (ev_asleep)
    );

    eiw_seq #(.PC_W(PC_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ev_awake  (ev_awake),
        .ev_asleep (ev_asleep),
        .int_en    (int_en),
        .gie_wr    (gie_wr),
        .gie_wdata (gie_wdata),
        .flag_clr  (flag_clr),
        .sleep_req (sleep_req),
        .retire    (retire),
        .vec_ack   (vec_ack),
        .pc_in     (pc_in),
        .status    (stat),
        .ret_pc    (ret_pc),
        .edge_ev   (edge_ev),
        .armed     (asleep)
    );

    always_comb begin
        irq_flag  = stat.flag;
        gie       = stat.gie;
        wake      = stat.wake;
        vec_req   = stat.vreq;
        push_req  = stat.vreq;
        push_pc   = ret_pc;
        vec_addr  = VEC_ADDR;
        wait_pend = stat.wait_ack;
    end

endmodule

// File: rtl/eiw_chk.sv
module eiw_chk #(
    parameter int PC_W = 13
) (
    input logic            clk,
    input logic            rst,
    input logic            int_en,
    input logic            flag_clr,
    input logic            vec_ack,
    input logic [PC_W-1:0] pc_in,
    input logic            flag_o,
    input logic            gie_o,
    input logic            wake_o,
    input logic            vec_req_o,
    input logic [PC_W-1:0] push_pc_o,
    input logic            edge_ev,
    input logic            wait_pend,
    input logic            asleep
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !flag_clr) |=> flag_o); // R3

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && edge_ev) |=> flag_o); // R4

    AST_VREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        vec_req_o |=> !vec_req_o); // R5

    AST_VREQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        vec_req_o |-> $past(flag_o && int_en && gie_o)); // R5

    AST_PUSH_PC: assert property (@(posedge clk) disable iff (rst)
        vec_req_o |-> (push_pc_o == $past(pc_in))); // R6

    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && wait_pend) |=> !gie_o); // R7

    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(int_en && flag_o)); // R8

    AST_NO_VREQ_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        asleep |-> !vec_req_o); // R11

endmodule

bind ext_irq_wake_ctrl eiw_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .int_en    (int_en),
    .flag_clr  (flag_clr),
    .vec_ack   (vec_ack),
    .pc_in     (pc_in),
    .flag_o    (irq_flag),
    .gie_o     (gie),
    .wake_o    (wake),
    .vec_req_o (vec_req),
    .push_pc_o (push_pc),
    .edge_ev   (edge_ev),
    .wait_pend (wait_pend),
    .asleep    (asleep)
);

// File: tb/ext_irq_wake_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_wake_ctrl_tb;
    localparam int PC_W = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_pin = 1'b0, rise_sel = 1'b0, int_en = 1'b0;
    logic gie_wr = 1'b0, gie_wdata = 1'b0, flag_clr = 1'b0;
    logic sleep_req = 1'b0, retire = 1'b0, vec_ack = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic irq_flag, gie, wake, vec_req, push_req;
    logic [PC_W-1:0] vec_addr, push_pc;

    int n_chk = 0, n_err = 0;
    int vreq_cnt = 0, wake_cnt = 0;
    int vbase, wbase;
    bit done = 0;

    // reference model state
    int   m_st = 0;             // 0 run, 1 asleep, 2 resume
    logic m_flag = 0, m_gie = 0, m_wait = 0, m_vreq = 0, m_wake = 0;
    logic [PC_W-1:0] m_pc = '0;
    logic m_s1 = 0, m_s2 = 0, m_s3 = 0;  // pin samples 1,2,3 edges ago
    logic m_lat = 0, m_l1 = 0, m_l2 = 0;

    always #5 clk = ~clk;

    ext_irq_wake_ctrl #(.PC_W(PC_W)) u_dut (
        .clk(clk), .rst(rst), .irq_pin(irq_pin), .rise_sel(rise_sel),
        .int_en(int_en), .gie_wr(gie_wr), .gie_wdata(gie_wdata),
        .flag_clr(flag_clr), .sleep_req(sleep_req), .pc_in(pc_in),
        .retire(retire), .vec_ack(vec_ack), .irq_flag(irq_flag), .gie(gie),
        .wake(wake), .vec_req(vec_req), .vec_addr(vec_addr),
        .push_req(push_req), .push_pc(push_pc)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input logic v);
        if (m_st == 1 && v !== irq_pin && (rise_sel ? v : !v)) m_lat = 1;
        irq_pin = v;
    endtask

    task automatic pulse_clr();
        flag_clr = 1; cyc(1); flag_clr = 0;
    endtask

    task automatic write_gie(input logic v);
        gie_wr = 1; gie_wdata = v; cyc(1); gie_wr = 0;
    endtask

    // behavioural reference, updated on every edge from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_flag = 0; m_gie = 0; m_wait = 0; m_vreq = 0; m_wake = 0;
            m_pc = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_lat = 0; m_l1 = 0; m_l2 = 0;
        end else begin
            logic s_ev, ev, take, n_wake;
            int   n_st;
            s_ev   = rise_sel ? (m_s2 && !m_s3) : (!m_s2 && m_s3);
            ev     = (m_st == 1) ? m_l2 : s_ev;
            take   = (m_st == 0) && m_flag && int_en && m_gie && !m_wait;
            n_wake = (m_st == 1) && m_flag && int_en;
            n_st   = m_st;
            if (m_st == 0 && sleep_req && !take && !m_wait) n_st = 1;
            else if (m_st == 1 && n_wake) n_st = 2;
            else if (m_st == 2 && retire) n_st = 0;
            if (vec_ack && m_wait) m_gie = 0; else if (gie_wr) m_gie = gie_wdata;
            if (take) m_wait = 1; else if (vec_ack) m_wait = 0;
            if (ev) m_flag = 1; else if (flag_clr) m_flag = 0;
            m_vreq = take;
            if (take) m_pc = pc_in;
            m_wake = n_wake;
            m_l2 = (m_st == 1) ? m_l1 : 1'b0;
            m_l1 = (m_st == 1) ? m_lat : 1'b0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_pin;
            m_st = n_st;
            if (m_st != 1) m_lat = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3", "irq_flag", irq_flag, m_flag);
            chk("R7", "gie", gie, m_gie);
            chk("R8", "wake", wake, m_wake);
            chk("R5", "vec_req", vec_req, m_vreq);
            chk("R6", "push_req", push_req, m_vreq);
            chk("R6", "push_pc", push_pc, m_pc);
            chk("R5", "vec_addr", vec_addr, 32'h4);
            if (vec_req) vreq_cnt++;
            if (wake) wake_cnt++;
        end
    end

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 0;
        chk("R12", "flag", irq_flag, 0); chk("R12", "gie", gie, 0);
        chk("R12", "wake", wake, 0); chk("R12", "vec_req", vec_req, 0);
        chk("R12", "push_req", push_req, 0); chk("R12", "push_pc", push_pc, 0);

        // polarity
        rise_sel = 1; set_pin(1); cyc(3);
        chk("R1", "rise sets flag", irq_flag, 1);
        pulse_clr(); cyc(1);
        chk("R3", "clear", irq_flag, 0);
        set_pin(0); cyc(4);
        chk("R1", "fall ignored", irq_flag, 0);
        rise_sel = 0; set_pin(1); cyc(4);
        chk("R2", "rise ignored", irq_flag, 0);
        set_pin(0); cyc(3);
        chk("R2", "fall sets flag", irq_flag, 1);
        cyc(5);
        chk("R3", "sticky without enables", irq_flag, 1);
        pulse_clr();

        // clear and edge on the same edge
        set_pin(1); cyc(4); set_pin(0); cyc(2);
        flag_clr = 1; cyc(1); flag_clr = 0; cyc(1);
        chk("R4", "edge wins", irq_flag, 1);

        // vectoring
        int_en = 1; pc_in = 13'h0123; write_gie(1); cyc(1);
        chk("R5", "request", vec_req, 1);
        chk("R6", "push", push_req, 1);
        chk("R6", "pc", push_pc, 13'h0123);
        cyc(1);
        chk("R5", "one cycle", vec_req, 0);
        cyc(3);
        chk("R7", "no re-request", vec_req, 0);
        chk("R7", "gie held before ack", gie, 1);
        chk("R6", "flag kept", irq_flag, 1);
        vec_ack = 1; cyc(1); vec_ack = 0;
        chk("R7", "ack clears gie", gie, 0);
        cyc(2); #1 vbase = vreq_cnt;

        flag_clr = 1; gie_wr = 1; gie_wdata = 1; cyc(1);
        flag_clr = 0; gie_wr = 0; cyc(4);
        #1 chk("R5", "no flag no request", vreq_cnt, vbase);
        int_en = 0; set_pin(1); cyc(4); set_pin(0); cyc(6);
        chk("R3", "flag with en off", irq_flag, 1);
        #1 chk("R5", "no en no request", vreq_cnt, vbase);
        int_en = 1; pc_in = 13'h0456; cyc(2);
        #1 chk("R5", "en late request", vreq_cnt, vbase + 1);
        chk("R6", "pc2", push_pc, 13'h0456);
        vec_ack = 1; cyc(1); vec_ack = 0;
        pulse_clr(); write_gie(0);

        // sleep, wake with gie off
        rise_sel = 1;
        sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
        #1 wbase = wake_cnt;
        set_pin(1); cyc(6);
        #1 chk("R8", "wake", wake_cnt, wbase + 1);
        chk("R8", "flag in sleep", irq_flag, 1);
        retire = 1; cyc(1); retire = 0; cyc(3);
        #1 chk("R10", "no vector", vreq_cnt, vbase + 1);

        // sleep with enable off
        pulse_clr(); int_en = 0; set_pin(0); cyc(4);
        sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
        set_pin(1); cyc(6);
        chk("R9", "flag set", irq_flag, 1);
        #1 chk("R9", "no wake", wake_cnt, wbase + 1);
        int_en = 1; cyc(2);
        #1 chk("R8", "late enable wakes", wake_cnt, wbase + 2);
        retire = 1; cyc(1); retire = 0;

        // sleep, wake with gie on
        pulse_clr(); write_gie(1); set_pin(0); cyc(4);
        sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
        set_pin(1); cyc(6);
        #1 chk("R11", "woke", wake_cnt, wbase + 3);
        chk("R11", "held before retire", vreq_cnt, vbase + 1);
        cyc(4);
        #1 chk("R11", "still held", vreq_cnt, vbase + 1);
        retire = 1; cyc(1); retire = 0; cyc(2);
        #1 chk("R11", "vector after retire", vreq_cnt, vbase + 2);
        vec_ack = 1; cyc(1); vec_ack = 0; cyc(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule